// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Level Triggers and DMA Requests

This block buffers the bytes exchanged between a processor or DMA engine and a serial line engine. One 16-entry byte FIFO carries bytes toward the line (transmit). A second carries bytes received from the line toward the processor (receive). Each FIFO is written and read through plain push/pop strobes. The oldest byte is always visible on the read-data port. The current fill level is exported.

Each direction has its own three-bit trigger selector, which picks a threshold as a fraction of the FIFO depth. The block compares each fill level with its threshold. From that comparison it drives a level interrupt and a burst DMA request for the direction. It also drives a single DMA request that tracks whether a byte or a free slot is available. An end-of-transmission interrupt combines an empty transmit FIFO with the line engine's report that its last stop bit has left the wire.

A one-entry mode shrinks both FIFOs to a capacity of one byte. This gives conventional double-buffered holding-register behaviour. A push into a full FIFO is discarded and sets a sticky overrun flag.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset both fill counts are 0, both FIFOs report empty, both overrun flags are 0, the transmit single DMA request is 1 and the receive single DMA request is 0.
- R2: Each FIFO returns bytes in the order they were accepted, and its read-data port shows the oldest stored byte whenever the count is non-zero.
- R3: The capacity is 16 bytes when one_entry mode is 0 and 1 byte when it is 1. The full output is 1 exactly when the count equals the capacity.
- R4: A push into a full FIFO with no pop in the same cycle is discarded. The count and the stored bytes stay unchanged, and the direction's overrun flag becomes 1 on the next cycle.
- R5: An overrun flag stays 1 until its clear strobe is pulsed, and then reads 0 on the next cycle. If a discarded push and a clear happen in the same cycle, the flag is 1.
- R6: A push and a pop in the same cycle on a full FIFO are both performed. The oldest byte leaves, the new byte is stored, and the count is unchanged.
- R7: A pop on an empty FIFO has no effect. If it coincides with a push, only the push takes place.
- R8: Trigger selector codes 0, 1, 2, 3 and 4 select thresholds of 2, 4, 8, 12 and 14 entries (1/8, 1/4, 1/2, 3/4 and 7/8 of 16). Codes 5 to 7 select 14. In one_entry mode the receive threshold is 1 and the transmit threshold is 0, whatever the selector.
- R9: The receive level interrupt and the receive burst DMA request are 1 exactly when the receive count is at or above the receive threshold.
- R10: The transmit level interrupt and the transmit burst DMA request are 1 exactly when the transmit count is at or below the transmit threshold.
- R11: The receive single DMA request is 1 exactly when the receive count is non-zero. The transmit single DMA request is 1 exactly when the transmit count is below the capacity.
- R12: The end-of-transmission interrupt is 1 exactly when the transmit FIFO is empty and line_done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| one_entry | input | 1 | 1 = both FIFOs hold a single byte |
| tx_trig_sel | input | 3 | Transmit threshold selector |
| rx_trig_sel | input | 3 | Receive threshold selector |
| tx_push | input | 1 | Write strobe from processor/DMA side |
| tx_wdata | input | 8 | Byte to transmit |
| tx_ovr_clr | input | 1 | Clears the transmit overrun flag |
| tx_pop | input | 1 | Line engine takes the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_count | output | 5 | Transmit fill level |
| tx_full | output | 1 | Transmit FIFO at capacity |
| tx_empty | output | 1 | Transmit FIFO holds nothing |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_push | input | 1 | Line engine delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_ovr_clr | input | 1 | Clears the receive overrun flag |
| rx_pop | input | 1 | Processor/DMA takes the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_count | output | 5 | Receive fill level |
| rx_full | output | 1 | Receive FIFO at capacity |
| rx_empty | output | 1 | Receive FIFO holds nothing |
| rx_overrun | output | 1 | Sticky receive overrun |
| line_done | input | 1 | Line engine has sent the final stop bit and is idle |
| tx_level_irq | output | 1 | Transmit level interrupt |
| rx_level_irq | output | 1 | Receive level interrupt |
| eot_irq | output | 1 | End-of-transmission interrupt |
| tx_dma_single | output | 1 | Transmit single DMA request |
| tx_dma_burst | output | 1 | Transmit burst DMA request |
| rx_dma_single | output | 1 | Receive single DMA request |
| rx_dma_burst | output | 1 | Receive burst DMA request |

## Verification
The risky coincidences are a push and a pop in the same cycle while a FIFO is full or empty, and a discarded push meeting an overrun clear. The bench drives each of these directly: it fills a FIFO to 16 (and to 1 in one_entry mode) and then strobes both sides together. Random traffic also biases push and pop toward the boundaries. The bench judges each case against its own queue model. The count must be unchanged for a full push-and-pop and must rise by one for an empty one. The byte order must hold across the wrap. The overrun flag must read 1 when set and clear coincide.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [2:0] {
        TRIG_EIGHTH   = 3'd0,
        TRIG_QUARTER  = 3'd1,
        TRIG_HALF     = 3'd2,
        TRIG_3QUARTER = 3'd3,
        TRIG_7EIGHTHS = 3'd4
    } trig_sel_e;

    // Threshold in entries for a selector code; unused codes fall to 7/8.
    function automatic int unsigned trig_entries(input logic [2:0] sel,
                                                 input int unsigned depth);
        case (sel)
            TRIG_EIGHTH:   return depth / 8;
            TRIG_QUARTER:  return depth / 4;
            TRIG_HALF:     return depth / 2;
            TRIG_3QUARTER: return (depth * 3) / 4;
            default:       return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             one_entry,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    input  logic             ovr_clr,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output logic             overrun
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
        logic                        ovr;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    logic [CW-1:0] cap;
    logic          pop_ok;
    logic          push_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        cap     = one_entry ? CW'(1) : CW'(DEPTH);
        pop_ok  = pop && (st_q.cnt != '0);
        push_ok = push && ((st_q.cnt < cap) || pop_ok);

        if (push_ok) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase

        if (push && !push_ok) begin
            st_d.ovr = 1'b1;
        end else if (ovr_clr) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.mem[st_q.rp];
    assign count   = st_q.cnt;
    assign full    = (st_q.cnt >= cap);
    assign empty   = (st_q.cnt == '0);
    assign overrun = st_q.ovr;

endmodule

// File: rtl/uart_fifo_watch.sv
module uart_fifo_watch
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b0,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          one_entry,
    input  logic [2:0]    trig_sel,
    input  logic [CW-1:0] count,
    output logic          level_hit,
    output logic          dma_single,
    output logic          dma_burst
);

    logic [CW-1:0] thr;
    logic [CW-1:0] cap;

    always_comb begin
        cap = one_entry ? CW'(1) : CW'(DEPTH);
        if (one_entry) begin
            thr = IS_RX ? CW'(1) : CW'(0);
        end else begin
            thr = CW'(trig_entries(trig_sel, DEPTH));
        end
    end

    generate
        if (IS_RX) begin : g_rx
            assign level_hit  = (count >= thr);
            assign dma_single = (count != '0);
        end else begin : g_tx
            assign level_hit  = (count <= thr);
            assign dma_single = (count < cap);
        end
    endgenerate

    assign dma_burst = level_hit;

endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             one_entry,
    input  logic [2:0]       tx_trig_sel,
    input  logic [2:0]       rx_trig_sel,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_wdata,
    input  logic             tx_ovr_clr,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_rdata,
    output logic [CW-1:0]    tx_count,
    output logic             tx_full,
    output logic             tx_empty,
    output logic             tx_overrun,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_wdata,
    input  logic             rx_ovr_clr,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_rdata,
    output logic [CW-1:0]    rx_count,
    output logic             rx_full,
    output logic             rx_empty,
    output logic             rx_overrun,
    input  logic             line_done,
    output logic             tx_level_irq,
    output logic             rx_level_irq,
    output logic             eot_irq,
    output logic             tx_dma_single,
    output logic             tx_dma_burst,
    output logic             rx_dma_single,
    output logic             rx_dma_burst
);

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .one_entry(one_entry),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .ovr_clr(tx_ovr_clr),
        .rdata(tx_rdata), .count(tx_count), .full(tx_full),
        .empty(tx_empty), .overrun(tx_overrun)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .one_entry(one_entry),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .ovr_clr(rx_ovr_clr),
        .rdata(rx_rdata), .count(rx_count), .full(rx_full),
        .empty(rx_empty), .overrun(rx_overrun)
    );

    uart_fifo_watch #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_watch (
        .one_entry(one_entry), .trig_sel(tx_trig_sel), .count(tx_count),
        .level_hit(tx_level_irq), .dma_single(tx_dma_single), .dma_burst(tx_dma_burst)
    );

    uart_fifo_watch #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_watch (
        .one_entry(one_entry), .trig_sel(rx_trig_sel), .count(rx_count),
        .level_hit(rx_level_irq), .dma_single(rx_dma_single), .dma_burst(rx_dma_burst)
    );

    assign eot_irq = tx_empty & line_done;

endmodule

// File: rtl/uart_fifo_dma_chk.sv
module uart_fifo_dma_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          tx_full,
    input logic          tx_empty,
    input logic          tx_overrun,
    input logic          tx_ovr_clr,
    input logic [CW-1:0] tx_count,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          rx_empty,
    input logic          rx_overrun,
    input logic          rx_ovr_clr,
    input logic [CW-1:0] rx_count,
    input logic          rx_dma_single,
    input logic          line_done,
    input logic          eot_irq
);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    // R4
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_pop) |=> (tx_overrun && $stable(tx_count)));

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_ovr_clr) |=> rx_overrun);

    // R5
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovr_clr && !tx_push) |=> !tx_overrun);

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty && !rx_push) |=> rx_empty);

    // R11
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_single == !rx_empty);

    // R12
    eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot_irq == (tx_empty && line_done));

endmodule

bind uart_fifo_dma uart_fifo_dma_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_overrun(tx_overrun), .tx_ovr_clr(tx_ovr_clr), .tx_count(tx_count),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_empty(rx_empty),
    .rx_overrun(rx_overrun), .rx_ovr_clr(rx_ovr_clr), .rx_count(rx_count),
    .rx_dma_single(rx_dma_single), .line_done(line_done), .eot_irq(eot_irq)
);

// File: tb/uart_fifo_dma_tb.sv
module uart_fifo_dma_tb;

    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       one_entry = 1'b0;
    logic [2:0] tx_trig_sel = 3'd0, rx_trig_sel = 3'd0;
    logic       tx_push = 0, tx_pop = 0, tx_ovr_clr = 0;
    logic       rx_push = 0, rx_pop = 0, rx_ovr_clr = 0;
    logic [7:0] tx_wdata = 0, rx_wdata = 0;
    logic       line_done = 0;
    logic [7:0] tx_rdata, rx_rdata;
    logic [4:0] tx_count, rx_count;
    logic       tx_full, tx_empty, tx_overrun, rx_full, rx_empty, rx_overrun;
    logic       tx_level_irq, rx_level_irq, eot_irq;
    logic       tx_dma_single, tx_dma_burst, rx_dma_single, rx_dma_burst;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit tovr = 0, rovr = 0;

    always #(CLK_NS/2) clk = ~clk;

    uart_fifo_dma u_dut (
        .clk(clk), .rst_n(rst_n), .one_entry(one_entry),
        .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_ovr_clr(tx_ovr_clr),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_count(tx_count),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_overrun(tx_overrun),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_ovr_clr(rx_ovr_clr),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_count(rx_count),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
        .line_done(line_done), .tx_level_irq(tx_level_irq),
        .rx_level_irq(rx_level_irq), .eot_irq(eot_irq),
        .tx_dma_single(tx_dma_single), .tx_dma_burst(tx_dma_burst),
        .rx_dma_single(rx_dma_single), .rx_dma_burst(rx_dma_burst)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R8 thresholds as specified, independent of the design
    function automatic int exp_thr(input logic [2:0] sel, input bit one, input bit rx);
        if (one) return rx ? 1 : 0;
        case (sel)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            default: return 14;
        endcase
    endfunction

    task automatic check_all();
        int cap = one_entry ? 1 : 16;
        int tn = txq.size();
        int rn = rxq.size();
        chk("R3 tx_count", tx_count, tn);
        chk("R3 rx_count", rx_count, rn);
        chk("R3 tx_full", tx_full, int'(tn == cap));
        chk("R3 rx_full", rx_full, int'(rn == cap));
        chk("R7 tx_empty", tx_empty, int'(tn == 0));
        chk("R7 rx_empty", rx_empty, int'(rn == 0));
        chk("R5 tx_overrun", tx_overrun, int'(tovr));
        chk("R5 rx_overrun", rx_overrun, int'(rovr));
        chk("R9 rx_level_irq", rx_level_irq, int'(rn >= exp_thr(rx_trig_sel, one_entry, 1)));
        chk("R9 rx_dma_burst", rx_dma_burst, int'(rn >= exp_thr(rx_trig_sel, one_entry, 1)));
        chk("R10 tx_level_irq", tx_level_irq, int'(tn <= exp_thr(tx_trig_sel, one_entry, 0)));
        chk("R10 tx_dma_burst", tx_dma_burst, int'(tn <= exp_thr(tx_trig_sel, one_entry, 0)));
        chk("R11 rx_dma_single", rx_dma_single, int'(rn != 0));
        chk("R11 tx_dma_single", tx_dma_single, int'(tn < cap));
        chk("R12 eot_irq", eot_irq, int'(tn == 0 && line_done));
        if (tn != 0) chk("R2 tx_rdata", tx_rdata, txq[0]);
        if (rn != 0) chk("R2 rx_rdata", rx_rdata, rxq[0]);
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit tp, input bit to, input bit rp, input bit ro,
                        input logic [7:0] twd, input logic [7:0] rwd,
                        input bit tc, input bit rc, input bit ld);
        int cap = one_entry ? 1 : 16;
        bit tpop, tpush, rpop, rpush;
        tx_push = tp; tx_pop = to; rx_push = rp; rx_pop = ro;
        tx_wdata = twd; rx_wdata = rwd; tx_ovr_clr = tc; rx_ovr_clr = rc;
        line_done = ld;
        @(posedge clk);
        tpop  = to && txq.size() > 0;
        tpush = tp && (txq.size() < cap || tpop);
        rpop  = ro && rxq.size() > 0;
        rpush = rp && (rxq.size() < cap || rpop);
        if (tp && !tpush) tovr = 1; else if (tc) tovr = 0;
        if (rp && !rpush) rovr = 1; else if (rc) rovr = 0;
        if (tpop) void'(txq.pop_front());
        if (tpush) txq.push_back(twd);
        if (rpop) void'(rxq.pop_front());
        if (rpush) rxq.push_back(rwd);
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_ovr_clr = 0; rx_ovr_clr = 0;
        check_all();
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 0;
        one_entry = mode;
        txq.delete(); rxq.delete(); tovr = 0; rovr = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        // R1 reset state
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 overrun", {tx_overrun, rx_overrun}, 0);
        chk("R1 tx_dma_single", tx_dma_single, 1);
        chk("R1 rx_dma_single", rx_dma_single, 0);

        // R8 threshold sweep on receive and transmit while filling to 16
        for (int s = 0; s < 8; s++) begin
            rx_trig_sel = 3'(s);
            tx_trig_sel = 3'(7 - s);
            for (int i = 0; i < 16; i++)
                step(1, 0, 1, 0, 8'(i + 16*s), 8'(255 - i), 0, 0, 0);
            // R4 push into full is dropped, overrun set
            step(1, 0, 1, 0, 8'hEE, 8'hDD, 0, 0, 0);
            // R6 push and pop together on a full FIFO
            step(1, 1, 1, 1, 8'hA5, 8'h5A, 0, 0, 0);
            // R5 discarded push with clear: set wins
            step(1, 0, 1, 0, 8'h11, 8'h22, 1, 1, 0);
            // R5 clear alone
            step(0, 0, 0, 0, 0, 0, 1, 1, 0);
            for (int i = 0; i < 16; i++)
                step(0, 1, 0, 1, 0, 0, 0, 0, 1);
            // R7 pop on empty, then pop with push on empty
            step(0, 1, 0, 1, 0, 0, 0, 0, 1);
            step(1, 1, 1, 1, 8'h33, 8'h44, 0, 0, 1);
            step(0, 1, 0, 1, 0, 0, 0, 0, 0);
        end

        // Random traffic, normal mode
        for (int n = 0; n < 3000; n++) begin
            if (n % 200 == 0) begin
                tx_trig_sel = 3'($urandom_range(0, 7));
                rx_trig_sel = 3'($urandom_range(0, 7));
            end
            step($urandom_range(0, 99) < ((n / 300) % 2 ? 70 : 35),
                 $urandom_range(0, 99) < ((n / 300) % 2 ? 35 : 70),
                 $urandom_range(0, 99) < 55, $urandom_range(0, 99) < 50,
                 8'($urandom), 8'($urandom),
                 $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0,
                 1'($urandom_range(0, 1)));
        end

        // One-entry mode: directed boundary then random (R3, R8)
        do_reset(1'b1);
        step(1, 0, 1, 0, 8'h81, 8'h82, 0, 0, 0);
        step(1, 0, 1, 0, 8'h91, 8'h92, 0, 0, 0);
        step(1, 1, 1, 1, 8'hA1, 8'hA2, 0, 0, 1);
        step(0, 1, 0, 1, 0, 0, 1, 1, 1);
        for (int n = 0; n < 1500; n++) begin
            tx_trig_sel = 3'($urandom_range(0, 7));
            rx_trig_sel = 3'($urandom_range(0, 7));
            step($urandom_range(0, 99) < 60, $urandom_range(0, 99) < 50,
                 $urandom_range(0, 99) < 60, $urandom_range(0, 99) < 50,
                 8'($urandom), 8'($urandom),
                 $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule